// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This unit records the exceptions raised by a floating-point coprocessor and decides when a trap must be taken. Each finished operation is handed over as a completion record. The record carries eight raw exception flags, a kind code and the address of the instruction. An arithmetic completion replaces the per-instruction status byte and ORs a folded summary into a sticky accrued byte. It then compares the new status with the enable byte. When an enabled condition is present, a trap becomes pending, the instruction address is latched and a vector naming the winning source is stored.

The trap is not signalled against the instruction that caused it. It is reported when the host next attempts a floating-point instruction (`start_valid`). At that point `exc_take` answers in the same cycle. The host clears the pending trap with a one-cycle `exc_ack`. The result of the faulting operation is produced by other logic exactly as if no trap were enabled. This unit adds only the take indication.

Completions arrive on a valid/ready stream. A record transfers on a clock edge where both `cmp_valid` and `cmp_ready` are high. `cmp_ready` drops while a trap is pending, so the producer must hold its record until the acknowledge. Records offered while `cmp_ready` is low have no effect.

Top module: `fpx_exc_unit`

## Requirements
- R1: While reset is asserted and after it is released: status, accrued and enable bytes are zero, `trap_pend` is 0, `trap_vec` and `fault_addr` are zero, and `cmp_ready` is 1.
- R2: An accepted completion of kind 0 (arithmetic) replaces `stat_byte` with `cmp_flags` from the next cycle on. The flag bits are: 7 unordered-branch, 6 signaling NaN, 5 operand error, 4 overflow, 3 underflow, 2 divide-by-zero, 1 decimal-input inexact, 0 other inexact.
- R3: An accepted arithmetic completion ORs a 5-bit contribution into `accr_byte`. Bit 4 is the OR of flags 7, 6 and 5. Bit 3 is flag 4. Bit 2 is flag 3. Bit 1 is flag 2. Bit 0 is the OR of flags 1, 0 and 4, so overflow also sets accrued inexact. Accrued bits clear only on reset or on an accepted kind 3 completion, which loads `cmp_flags[4:0]` into `accr_byte`.
- R4: An accepted kind 1 completion (handler register move) changes none of the status, accrued or enable bytes and never raises a trap.
- R5: An accepted kind 2 completion loads `cmp_flags` into `ena_byte` and leaves `stat_byte` unchanged.
- R6: When an accepted arithmetic completion has any bit set in both `cmp_flags` and `ena_byte`, `trap_pend` is 1 from the next cycle on and `fault_addr` holds that completion's `cmp_addr`.
- R7: An accepted arithmetic completion with flag 4 set, enable bit 4 clear, and enable bit 1 or bit 0 set raises a trap with vector 0, even when flags 1 and 0 are clear. This applies only when no flag that is both set and enabled is present.
- R8: `trap_vec` is the index of the highest set bit of `cmp_flags & ena_byte` of the trapping completion. The order runs from bit 7 (highest priority) down to bit 0.
- R9: `exc_take` equals `start_valid && trap_pend` in the same cycle. A trap raised by a completion accepted in a cycle where `start_valid` is high is not taken in that cycle.
- R10: `cmp_ready` equals `!trap_pend`. A completion offered while `cmp_ready` is 0 changes no byte, no vector and no address.
- R11: `exc_ack` while `trap_pend` is 1 clears `trap_pend` in the next cycle. `trap_vec` and `fault_addr` keep their values until the next trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_valid | input | 1 | Completion record offered |
| cmp_ready | output | 1 | Completion can be accepted (no trap pending) |
| cmp_kind | input | 2 | 0 arithmetic, 1 register move, 2 enable write, 3 accrued write |
| cmp_flags | input | 8 | Raw exception flags, or the data for a write |
| cmp_addr | input | AW | Address of the completing instruction |
| start_valid | input | 1 | Host attempts the next floating-point instruction |
| exc_ack | input | 1 | One-cycle acknowledge of the pending trap |
| exc_take | output | 1 | Take-exception answer to the instruction start |
| trap_pend | output | 1 | A trap is waiting to be reported |
| trap_vec | output | 3 | Source of the pending or last trap |
| fault_addr | output | AW | Address of the instruction that raised the trap |
| stat_byte | output | 8 | Per-instruction exception status |
| accr_byte | output | 5 | Sticky accrued exceptions |
| ena_byte | output | 8 | Trap enable mask |

## Verification
Two pairs of functions can meet in one cycle. In the first, an arithmetic completion that raises a trap is accepted while `start_valid` is high. The bench drives both in the same cycle and expects `exc_take` low in that cycle and high only on a later start. In the second, an acknowledge arrives together with an instruction start. There the take must still be answered from the old pending state before the clear lands. Both pairs are forced in directed steps and then recur in a long random stretch. That stretch also covers offers during back-pressure and overflow with inexact enabled. Every clock is compared against a behavioural reference model.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NFLAG = 8;
  localparam int VW    = $clog2(NFLAG);
  localparam int NACC  = 5;

  // raw flag positions (priority: higher index wins)
  localparam int F_BSUN  = 7;
  localparam int F_SNAN  = 6;
  localparam int F_OPERR = 5;
  localparam int F_OVFL  = 4;
  localparam int F_UNFL  = 3;
  localparam int F_DZ    = 2;
  localparam int F_INEXD = 1;
  localparam int F_INEXO = 0;

  // accrued positions
  localparam int A_IOP  = 4;
  localparam int A_OVFL = 3;
  localparam int A_UNFL = 2;
  localparam int A_DZ   = 1;
  localparam int A_INEX = 0;

  typedef enum logic [1:0] {
    K_ARITH = 2'd0,
    K_MOVE  = 2'd1,
    K_WENA  = 2'd2,
    K_WACC  = 2'd3
  } op_kind_e;
endpackage

// File: rtl/fpx_accrue.sv
module fpx_accrue
  import fpx_pkg::*;
(
  input  logic [NFLAG-1:0] flags,
  output logic [NACC-1:0]  contrib
);
  always_comb begin
    contrib         = '0;
    contrib[A_IOP]  = flags[F_BSUN] | flags[F_SNAN] | flags[F_OPERR];
    contrib[A_OVFL] = flags[F_OVFL];
    contrib[A_UNFL] = flags[F_UNFL];
    contrib[A_DZ]   = flags[F_DZ];
    // overflow counts as inexact in the accrued byte
    contrib[A_INEX] = flags[F_INEXD] | flags[F_INEXO] | flags[F_OVFL];
  end
endmodule

// File: rtl/fpx_status_regs.sv
module fpx_status_regs
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  op_kind_e         kind,
  input  logic [NFLAG-1:0] flags,
  input  logic [NACC-1:0]  contrib,
  output logic [NFLAG-1:0] stat,
  output logic [NACC-1:0]  accr,
  output logic [NFLAG-1:0] ena
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      accr <= '0;
      ena  <= '0;
    end else if (acc) begin
      case (kind)
        K_ARITH: begin
          stat <= flags;
          accr <= accr | contrib;
        end
        K_WENA:  ena  <= flags;
        K_WACC:  accr <= flags[NACC-1:0];
        default: ;
      endcase
    end
  end

  // R3
  accr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && kind == K_ARITH |=> ((accr & $past(accr)) == $past(accr)));

  // R3
  accr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(accr));

  // R4
  move_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && kind == K_MOVE |=> $stable(stat) && $stable(accr) && $stable(ena));

  // R5
  ena_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && kind == K_WENA |=> $stable(stat));
endmodule

// File: rtl/fpx_trap_pick.sv
module fpx_trap_pick #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N-1:0] above;
  logic [N-1:0] win;

  assign above[N-1] = 1'b0;
  assign win[N-1]   = req[N-1];

  genvar g;
  generate
    for (g = 0; g < N - 1; g++) begin : g_rank
      assign above[g] = above[g+1] | req[g+1];
      assign win[g]   = req[g] & ~above[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (win[i]) idx = idx | IW'(i);
    end
  end

  assign any = |req;

  // R8
  always_comb begin
    win_onehot_chk: assert ($onehot0(win));
  end
endmodule

// File: rtl/fpx_trap_ctl.sv
module fpx_trap_ctl #(
  parameter int AW = 32,
  parameter int VW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raise,
  input  logic [VW-1:0] raise_vec,
  input  logic [AW-1:0] raise_addr,
  input  logic          ack,
  output logic          pend,
  output logic [VW-1:0] vec,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      vec  <= '0;
      addr <= '0;
    end else if (pend && ack) begin
      pend <= 1'b0;
    end else if (raise) begin
      pend <= 1'b1;
      vec  <= raise_vec;
      addr <= raise_addr;
    end
  end

  // R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && ack |=> !pend);

  // R11
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !ack |=> pend && $stable(vec) && $stable(addr));

  // R6
  raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise && !pend |=> pend && addr == $past(raise_addr));
endmodule

// File: rtl/fpx_exc_unit.sv
module fpx_exc_unit
  import fpx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmp_valid,
  output logic                 cmp_ready,
  input  logic [1:0]           cmp_kind,
  input  logic [NFLAG-1:0]     cmp_flags,
  input  logic [AW-1:0]        cmp_addr,
  input  logic                 start_valid,
  input  logic                 exc_ack,
  output logic                 exc_take,
  output logic                 trap_pend,
  output logic [VW-1:0]        trap_vec,
  output logic [AW-1:0]        fault_addr,
  output logic [NFLAG-1:0]     stat_byte,
  output logic [NACC-1:0]      accr_byte,
  output logic [NFLAG-1:0]     ena_byte
);
  op_kind_e        kind;
  logic            acc;
  logic            arith;
  logic [NACC-1:0] contrib;
  logic            hit_any;
  logic [VW-1:0]   hit_idx;
  logic            forced;
  logic            raise;
  logic [VW-1:0]   raise_vec;

  assign kind      = op_kind_e'(cmp_kind);
  assign cmp_ready = ~trap_pend;
  assign acc       = cmp_valid & cmp_ready;
  assign arith     = acc & (kind == K_ARITH);

  fpx_accrue u_accrue (
    .flags   (cmp_flags),
    .contrib (contrib)
  );

  fpx_status_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .kind    (kind),
    .flags   (cmp_flags),
    .contrib (contrib),
    .stat    (stat_byte),
    .accr    (accr_byte),
    .ena     (ena_byte)
  );

  fpx_trap_pick #(.N(NFLAG)) u_pick (
    .req (cmp_flags & ena_byte),
    .any (hit_any),
    .idx (hit_idx)
  );

  // overflow untrapped but an inexact trap enabled: report as inexact
  assign forced = cmp_flags[F_OVFL] & ~ena_byte[F_OVFL] &
                  (ena_byte[F_INEXD] | ena_byte[F_INEXO]);

  assign raise     = arith & (hit_any | forced);
  assign raise_vec = hit_any ? hit_idx : VW'(F_INEXO);

  fpx_trap_ctl #(.AW(AW), .VW(VW)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .raise      (raise),
    .raise_vec  (raise_vec),
    .raise_addr (cmp_addr),
    .ack        (exc_ack),
    .pend       (trap_pend),
    .vec        (trap_vec),
    .addr       (fault_addr)
  );

  assign exc_take = start_valid & trap_pend;

  // R7
  ovfl_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && !trap_pend && cmp_kind == 2'd0 && cmp_flags[F_OVFL] &&
    !ena_byte[F_OVFL] && (ena_byte[F_INEXD] || ena_byte[F_INEXO]) |=> trap_pend);

  // R10
  no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && trap_pend && !exc_ack |=>
      $stable(stat_byte) && $stable(accr_byte) && $stable(ena_byte));
endmodule

// File: tb/tb_fpx_exc_unit.sv
module tb_fpx_exc_unit;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_valid = 1'b0;
  logic          cmp_ready;
  logic [1:0]    cmp_kind = 2'd0;
  logic [7:0]    cmp_flags = 8'h00;
  logic [AW-1:0] cmp_addr = '0;
  logic          start_valid = 1'b0;
  logic          exc_ack = 1'b0;
  logic          exc_take;
  logic          trap_pend;
  logic [2:0]    trap_vec;
  logic [AW-1:0] fault_addr;
  logic [7:0]    stat_byte;
  logic [4:0]    accr_byte;
  logic [7:0]    ena_byte;

  always #2 clk = ~clk;

  fpx_exc_unit #(.AW(AW)) dut (
    .clk (clk), .rst_n (rst_n),
    .cmp_valid (cmp_valid), .cmp_ready (cmp_ready), .cmp_kind (cmp_kind),
    .cmp_flags (cmp_flags), .cmp_addr (cmp_addr),
    .start_valid (start_valid), .exc_ack (exc_ack), .exc_take (exc_take),
    .trap_pend (trap_pend), .trap_vec (trap_vec), .fault_addr (fault_addr),
    .stat_byte (stat_byte), .accr_byte (accr_byte), .ena_byte (ena_byte)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  logic [7:0]    m_stat, m_ena;
  logic [4:0]    m_accr;
  logic          m_pend;
  logic [2:0]    m_vec;
  logic [AW-1:0] m_addr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_ena = 0; m_accr = 0; m_pend = 0; m_vec = 0; m_addr = 0;
    end else if (m_pend && exc_ack) begin
      m_pend = 0;                                  // R11
    end else if (cmp_valid && !m_pend) begin       // R10
      case (cmp_kind)
        2'd0: begin                                // R2, R3, R6, R7, R8
          int win;
          m_stat = cmp_flags;
          m_accr[4] = m_accr[4] | cmp_flags[7] | cmp_flags[6] | cmp_flags[5];
          m_accr[3] = m_accr[3] | cmp_flags[4];
          m_accr[2] = m_accr[2] | cmp_flags[3];
          m_accr[1] = m_accr[1] | cmp_flags[2];
          m_accr[0] = m_accr[0] | cmp_flags[1] | cmp_flags[0] | cmp_flags[4];
          win = -1;
          for (int i = 7; i >= 0; i--)
            if (win < 0 && cmp_flags[i] && m_ena[i]) win = i;
          if (win < 0 && cmp_flags[4] && !m_ena[4] && (m_ena[1] || m_ena[0]))
            win = 0;
          if (win >= 0) begin
            m_pend = 1; m_vec = 3'(win); m_addr = cmp_addr;
          end
        end
        2'd2: m_ena = cmp_flags;                   // R5
        2'd3: m_accr = cmp_flags[4:0];             // R3
        default: ;                                 // R4
      endcase
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, after inputs settle, away from the rising edge
  always @(negedge clk) begin
    #1;
    if (!done) begin
      if (!rst_n) begin
        chk("R1 stat", stat_byte, 0);
        chk("R1 pend", trap_pend, 0);
        chk("R1 ready", cmp_ready, 1);
      end else begin
        chk("R2 stat_byte", stat_byte, m_stat);
        chk("R3 accr_byte", accr_byte, m_accr);
        chk("R5 ena_byte", ena_byte, m_ena);
        chk("R6 trap_pend", trap_pend, m_pend);
        chk("R6 fault_addr", fault_addr, m_addr);
        chk("R8 trap_vec", trap_vec, m_vec);
        chk("R9 exc_take", exc_take, start_valid && m_pend);
        chk("R10 cmp_ready", cmp_ready, !m_pend);
      end
    end
  end

  task automatic step(input logic v, input logic [1:0] k, input logic [7:0] f,
                      input logic [AW-1:0] a, input logic st, input logic ak);
    @(negedge clk);
    cmp_valid = v; cmp_kind = k; cmp_flags = f; cmp_addr = a;
    start_valid = st; exc_ack = ak;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values after release
    @(negedge clk); rst_n = 1'b1;
    idle();
    // R2, R3: no enables, no trap
    step(1, 0, 8'h0C, 32'h10, 0, 0);
    step(1, 0, 8'h01, 32'h14, 0, 0);
    idle();
    // R4: register move changes nothing
    step(1, 1, 8'hFF, 32'h18, 0, 0);
    idle();
    // R3: explicit accrued clear
    step(1, 3, 8'h00, 32'h1C, 0, 0);
    // R5: enable overflow and divide-by-zero
    step(1, 2, 8'h14, 32'h20, 0, 0);
    // R6, R8: overflow wins over underflow and dz -> vector 4
    step(1, 0, 8'h1C, 32'h100, 0, 0);
    // R10: offered while pending, ignored
    step(1, 0, 8'hFF, 32'h104, 0, 0);
    // R9: next instruction start
    step(0, 0, 0, 0, 1, 0);
    // R9, R11: start and acknowledge together
    step(0, 0, 0, 0, 1, 1);
    idle();
    // R7: only other-inexact enabled, overflow forces inexact trap; start coincides
    step(1, 2, 8'h01, 32'h24, 0, 0);
    step(1, 0, 8'h10, 32'h200, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1);
    idle();
    // R8: priority ordering
    step(1, 2, 8'hC2, 32'h28, 0, 0);
    step(1, 0, 8'hFF, 32'h300, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    step(1, 0, 8'h42, 32'h304, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    step(1, 0, 8'h02, 32'h308, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    // R7: overflow enabled -> no forcing; vector 4
    step(1, 2, 8'h13, 32'h2C, 0, 0);
    step(1, 0, 8'h10, 32'h30C, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    idle();
    // random mix of all functions
    for (int n = 0; n < 600; n++) begin
      step(1'($urandom), 2'($urandom), 8'($urandom & $urandom), $urandom,
           1'($urandom), ($urandom % 4) == 0);
    end
    idle();
    idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule